// File: doc/BRIEF.md
# Dual-Rail Fault and Power-Good Supervisor

This block is the digital supervisor for two regulated supply rails. Analog comparators outside the block watch each rail and report three conditions as flags: undervoltage, overvoltage and overcurrent. A further flag reports that the sensed differential output voltage has dropped below a safe floor. The supervisor filters these flags against glitches and steps through the states disabled, soft-start, regulating and latched-off. From those states it drives one power-good output in open-drain style, a global PWM inhibit, and one forced-low-side command per rail.

Undervoltage can be recovered from. It pulls power-good low only while it lasts. Overvoltage and overcurrent latch the controller off, and only power-on-reset clears the latch. On overvoltage the block turns on the low-side crowbar on every rail. The crowbar stays on until the differential voltage falls below the floor, and it comes back each time overvoltage returns while the controller is latched.

Top module: `dual_rail_supervisor`

## Requirements
- R1: `pg_ok` (1 = released high, 0 = pulled low) stays 0 in the disabled and soft-start states. It goes to 1 on the same clock edge that the controller enters the regulating state. The controller enters that state once every bit of `ss_done` is 1 and no filtered fault is present.
- R2: When `en` is 0 and the controller is not latched, the controller is disabled. In that state `pg_ok` is 0 and `pwm_inhibit` is 1, and fault flags have no effect: no latch and no crowbar.
- R3: An undervoltage on any rail during regulation drives `pg_ok` to 0 without setting `pwm_inhibit`. `pg_ok` returns to 1 once all filtered flags have cleared.
- R4: A filtered overvoltage on any rail during soft-start or regulation latches the controller off. This sets `pwm_inhibit` to 1, `pg_ok` to 0, and every bit of `lsd_force` to 1.
- R5: After overvoltage, `lsd_force` stays all ones until the filtered `vdiff_low` is 1 and no overvoltage is present. Then it returns to 0.
- R6: While latched, each new filtered overvoltage sets `lsd_force` back to all ones. The crowbar holds even when `vdiff_low` is 1 for as long as the overvoltage persists.
- R7: A filtered overcurrent on any rail during soft-start or regulation latches the controller off, with `pwm_inhibit` = 1 and `pg_ok` = 0. It leaves `lsd_force` at 0.
- R8: Toggling `en` does not leave the latched state. Only `por_n` low clears it, after which a new soft-start can raise `pg_ok`.
- R9: A fault flag (`uv`, `ov`, `oc`, `vdiff_low`) is acted upon only after it has held a new level for FILT_CYC consecutive clock samples. A shorter pulse has no effect on any output.
- R10: While `por_n` is 0, the outputs are `pg_ok` = 0, `pwm_inhibit` = 1 and `lsd_force` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| por_n | input | 1 | Asynchronous active-low power-on-reset; the only way out of the latched state |
| en | input | 1 | Controller enable |
| ss_done | input | NRAIL | Per-rail soft-start complete |
| uv | input | NRAIL | Per-rail undervoltage comparator flag |
| ov | input | NRAIL | Per-rail overvoltage comparator flag |
| oc | input | NRAIL | Per-rail overcurrent comparator flag |
| vdiff_low | input | 1 | Sensed differential voltage below the crowbar release floor |
| pg_ok | output | 1 | Power-good, 1 = release the open-drain pin |
| pwm_inhibit | output | 1 | Global inhibit of normal PWM action |
| lsd_force | output | NRAIL | Per-rail command forcing the low-side switch on |

## Verification
The assertions check these properties on every cycle. Power-good is only high in the regulating state. A crowbar implies both the latched state and the inhibit. The latch never releases on its own. The crowbar never drops while the floor flag is low, and it re-arms on every overvoltage while latched. Disabling always pulls power-good low on the next edge. Other behaviour can only be shown by the bench's scenarios. These are glitch rejection by pulse length, recovery of power-good after an undervoltage ends, and the release order of the crowbar against the floor flag. They also cover overcurrent latching without a crowbar and a clean restart after power-on-reset.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_SOFT  = 2'd1,
        ST_RUN   = 2'd2,
        ST_LATCH = 2'd3
    } sup_state_e;
endpackage

// File: rtl/sup_flag_filter.sv
module sup_flag_filter #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic raw,
    output logic filt
);
    localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (raw != r_q.lvl) begin
            if (r_q.cnt == LAST) begin
                r_d.lvl = raw;
                r_d.cnt = '0;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end else begin
            r_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign filt = r_q.lvl;
endmodule

// File: rtl/sup_crowbar.sv
module sup_crowbar (
    input  logic clk,
    input  logic por_n,
    input  logic mon,
    input  logic ov_any,
    input  logic floor_hit,
    output logic crowbar
);
    typedef struct packed {
        logic on;
    } cb_t;

    cb_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (mon && ov_any)          r_d.on = 1'b1;
        else if (r_q.on && floor_hit) r_d.on = 1'b0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign crowbar = r_q.on;
endmodule

// File: rtl/sup_seq_fsm.sv
module sup_seq_fsm
    import sup_pkg::*;
#(
    parameter int NRAIL = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             en,
    input  logic [NRAIL-1:0] ss_done,
    input  logic [NRAIL-1:0] uv_f,
    input  logic [NRAIL-1:0] ov_f,
    input  logic [NRAIL-1:0] oc_f,
    output sup_state_e       st,
    output logic             pg
);
    typedef struct packed {
        sup_state_e st;
        logic       pg;
    } seq_t;

    seq_t r_d, r_q;
    logic hard_fault;
    logic window_ok;

    always_comb begin
        hard_fault = (|ov_f) || (|oc_f);
        window_ok  = !((|uv_f) || hard_fault);
        r_d = r_q;
        unique case (r_q.st)
            ST_OFF: begin
                if (en) r_d.st = ST_SOFT;
            end
            ST_SOFT: begin
                if (hard_fault)    r_d.st = ST_LATCH;
                else if (!en)      r_d.st = ST_OFF;
                else if (&ss_done) r_d.st = ST_RUN;
            end
            ST_RUN: begin
                if (hard_fault) r_d.st = ST_LATCH;
                else if (!en)   r_d.st = ST_OFF;
            end
            default: r_d.st = ST_LATCH;
        endcase
        r_d.pg = (r_d.st == ST_RUN) && window_ok;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) r_q <= '{st: ST_OFF, pg: 1'b0};
        else        r_q <= r_d;
    end

    assign st = r_q.st;
    assign pg = r_q.pg;
endmodule

// File: rtl/dual_rail_supervisor.sv
module dual_rail_supervisor
    import sup_pkg::*;
#(
    parameter int NRAIL    = 2,
    parameter int FILT_CYC = 4
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             en,
    input  logic [NRAIL-1:0] ss_done,
    input  logic [NRAIL-1:0] uv,
    input  logic [NRAIL-1:0] ov,
    input  logic [NRAIL-1:0] oc,
    input  logic             vdiff_low,
    output logic             pg_ok,
    output logic             pwm_inhibit,
    output logic [NRAIL-1:0] lsd_force
);
    logic [NRAIL-1:0] uv_f, ov_f, oc_f;
    logic             vdiff_f;
    logic             crowbar_q;
    sup_state_e       st_q;

    for (genvar i = 0; i < NRAIL; i++) begin : g_rail
        sup_flag_filter #(.FILT_CYC(FILT_CYC)) u_uv (
            .clk(clk), .por_n(por_n), .raw(uv[i]), .filt(uv_f[i]));
        sup_flag_filter #(.FILT_CYC(FILT_CYC)) u_ov (
            .clk(clk), .por_n(por_n), .raw(ov[i]), .filt(ov_f[i]));
        sup_flag_filter #(.FILT_CYC(FILT_CYC)) u_oc (
            .clk(clk), .por_n(por_n), .raw(oc[i]), .filt(oc_f[i]));
    end

    sup_flag_filter #(.FILT_CYC(FILT_CYC)) u_vdiff (
        .clk(clk), .por_n(por_n), .raw(vdiff_low), .filt(vdiff_f));

    sup_seq_fsm #(.NRAIL(NRAIL)) u_seq (
        .clk     (clk),
        .por_n   (por_n),
        .en      (en),
        .ss_done (ss_done),
        .uv_f    (uv_f),
        .ov_f    (ov_f),
        .oc_f    (oc_f),
        .st      (st_q),
        .pg      (pg_ok)
    );

    sup_crowbar u_cb (
        .clk       (clk),
        .por_n     (por_n),
        .mon       (st_q != ST_OFF),
        .ov_any    (|ov_f),
        .floor_hit (vdiff_f),
        .crowbar   (crowbar_q)
    );

    assign pwm_inhibit = (st_q == ST_OFF) || (st_q == ST_LATCH);
    assign lsd_force   = {NRAIL{crowbar_q}};
endmodule

// File: rtl/sup_checker.sv
module sup_checker
    import sup_pkg::*;
#(
    parameter int NRAIL = 2
) (
    input logic             clk,
    input logic             por_n,
    input logic             en,
    input logic             pg_ok,
    input logic             pwm_inhibit,
    input logic [NRAIL-1:0] lsd_force,
    input sup_state_e       st_q,
    input logic             crowbar_q,
    input logic [NRAIL-1:0] ov_f,
    input logic [NRAIL-1:0] oc_f,
    input logic             vdiff_f
);
    a_r1_pg_only_in_run: assert property (@(posedge clk) disable iff (!por_n)
        pg_ok |-> (st_q == ST_RUN));

    a_r2_disable_drops_pg: assert property (@(posedge clk) disable iff (!por_n)
        (!en && st_q != ST_LATCH) |=> !pg_ok);

    a_r4_crowbar_means_latched: assert property (@(posedge clk) disable iff (!por_n)
        (lsd_force != '0) |-> (pwm_inhibit && st_q == ST_LATCH && !pg_ok));

    a_r5_crowbar_holds: assert property (@(posedge clk) disable iff (!por_n)
        (crowbar_q && !vdiff_f) |=> crowbar_q);

    a_r6_rearm_on_ov: assert property (@(posedge clk) disable iff (!por_n)
        (st_q == ST_LATCH && (|ov_f)) |=> (lsd_force == '1));

    a_r7_oc_latches: assert property (@(posedge clk) disable iff (!por_n)
        ((|oc_f) && (st_q == ST_SOFT || st_q == ST_RUN)) |=> (st_q == ST_LATCH));

    a_r8_latch_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (st_q == ST_LATCH) |=> (st_q == ST_LATCH && pwm_inhibit));
endmodule

bind dual_rail_supervisor sup_checker #(.NRAIL(NRAIL)) u_sup_chk (
    .clk         (clk),
    .por_n       (por_n),
    .en          (en),
    .pg_ok       (pg_ok),
    .pwm_inhibit (pwm_inhibit),
    .lsd_force   (lsd_force),
    .st_q        (st_q),
    .crowbar_q   (crowbar_q),
    .ov_f        (ov_f),
    .oc_f        (oc_f),
    .vdiff_f     (vdiff_f)
);

// File: tb/tb_dual_rail_supervisor.sv
`timescale 1ns/1ps
module tb_dual_rail_supervisor;
    localparam int NRAIL = 2;
    localparam int FILT  = 4;
    localparam int W     = FILT + 2;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic en = 1'b0;
    logic [NRAIL-1:0] ss_done = '0, uv = '0, ov = '0, oc = '0;
    logic vdiff_low = 1'b0;
    logic pg_ok, pwm_inhibit;
    logic [NRAIL-1:0] lsd_force;

    always #4 clk = ~clk;

    dual_rail_supervisor #(.NRAIL(NRAIL), .FILT_CYC(FILT)) dut (
        .clk(clk), .por_n(por_n), .en(en), .ss_done(ss_done),
        .uv(uv), .ov(ov), .oc(oc), .vdiff_low(vdiff_low),
        .pg_ok(pg_ok), .pwm_inhibit(pwm_inhibit), .lsd_force(lsd_force));

    typedef struct {
        int          due;
        string       req;
        logic        pg;
        logic        inh;
        logic [NRAIL-1:0] lsd;
    } exp_t;

    exp_t sb[$];
    int cyc = 0, n_chk = 0, n_fail = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (pg_ok !== e.pg || pwm_inhibit !== e.inh || lsd_force !== e.lsd) begin
                n_fail++;
                $display("FAIL %s: got pg=%b inh=%b lsd=%b expected pg=%b inh=%b lsd=%b",
                         e.req, pg_ok, pwm_inhibit, lsd_force, e.pg, e.inh, e.lsd);
            end
        end
    end

    task automatic expect_now(string req, logic pg, logic inh, logic [NRAIL-1:0] lsd);
        exp_t e;
        e.due = cyc; e.req = req; e.pg = pg; e.inh = inh; e.lsd = lsd;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (W) @(negedge clk);
    endtask

    task automatic do_por();
        por_n = 1'b0;
        repeat (2) @(negedge clk);
        expect_now("R10", 1'b0, 1'b1, 2'b00);
        por_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expect_now("R10", 1'b0, 1'b1, 2'b00);
        por_n = 1'b1;

        ov = 2'b01; settle();
        expect_now("R2", 1'b0, 1'b1, 2'b00);
        ov = 2'b00; settle();

        en = 1'b1; settle();
        expect_now("R1", 1'b0, 1'b0, 2'b00);
        ss_done = 2'b11; settle();
        expect_now("R1", 1'b1, 1'b0, 2'b00);

        uv[1] = 1'b1; repeat (FILT - 1) @(negedge clk); uv[1] = 1'b0; settle();
        expect_now("R9", 1'b1, 1'b0, 2'b00);

        uv[0] = 1'b1; settle();
        expect_now("R3", 1'b0, 1'b0, 2'b00);
        uv[0] = 1'b0; settle();
        expect_now("R3", 1'b1, 1'b0, 2'b00);

        en = 1'b0; settle();
        expect_now("R2", 1'b0, 1'b1, 2'b00);
        en = 1'b1; settle();
        expect_now("R1", 1'b1, 1'b0, 2'b00);

        ov[1] = 1'b1; settle();
        expect_now("R4", 1'b0, 1'b1, 2'b11);
        ov = 2'b00; settle();
        expect_now("R5", 1'b0, 1'b1, 2'b11);
        vdiff_low = 1'b1; settle();
        expect_now("R5", 1'b0, 1'b1, 2'b00);
        ov[0] = 1'b1; settle();
        expect_now("R6", 1'b0, 1'b1, 2'b11);
        ov = 2'b00; settle();
        expect_now("R6", 1'b0, 1'b1, 2'b00);
        vdiff_low = 1'b0;

        en = 1'b0; settle(); en = 1'b1; settle();
        expect_now("R8", 1'b0, 1'b1, 2'b00);
        do_por(); settle();
        expect_now("R8", 1'b1, 1'b0, 2'b00);

        oc[1] = 1'b1; settle();
        expect_now("R7", 1'b0, 1'b1, 2'b00);
        oc = 2'b00; settle();
        expect_now("R7", 1'b0, 1'b1, 2'b00);

        do_por(); settle();
        ov[0] = 1'b1; repeat (FILT - 1) @(negedge clk); ov[0] = 1'b0; settle();
        expect_now("R9", 1'b1, 1'b0, 2'b00);

        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule